// File: doc/BRIEF.md
# Two-Entry Receive Character Buffer

This block sits between the receive shift register of an asynchronous serial port and the register read path. The shift register presents each completed character on a one-cycle strobe. The strobe carries up to nine data bits, a frame-error bit and a parity-error bit. The buffer keeps up to two such characters in arrival order, each with its own error bits. The status outputs always describe the oldest character that has not been read. A data read pops that character. The ninth data bit has its own output, so it must be sampled before the low-byte read pops the entry.

A character that completes while both entries are occupied is not lost straight away. It stays in a single hold slot that models the shift register, and it moves into the buffer in the same cycle that a read frees an entry. If a new start bit is reported first, the held character is dropped and the overrun flag is raised. Clearing the receiver enable empties the buffer and the hold slot, and clears every flag.

Top module: `serial_rx_buffer`

## Requirements
- R1: While `rstN` is low, and in the cycle after it rises, `rxComplete`, `rxIrq`, `frameErr`, `parityErr`, `overrun`, `rdBit8` and `rdData` are all zero.
- R2: `rxComplete` is one exactly when at least one unread character is stored. `rxIrq` equals `rxComplete` AND `rxcIntEnable`.
- R3: Characters are read in arrival order. A `readStrobe` pops the oldest character when the buffer is not empty. A `readStrobe` on an empty buffer changes nothing.
- R4: `frameErr` shows the frame-error bit that was captured with the oldest stored character. It changes only when that character is popped. It is zero when the buffer is empty.
- R5: `parityErr` shows the parity-error bit of the oldest character. That bit is stored as one only if `parityCheckOn` was high in the cycle the character arrived. `parityErr` is zero when the buffer is empty.
- R6: `sizeSel` at arrival sets the character width. Code 0 means 5 bits, 1 means 6, 2 means 7, 3 means 8 and 4 means 9. Codes 5 to 7 mean 8 bits. Data bits above the selected width are stored, and read, as zero.
- R7: `rdBit8` shows bit 8 of the oldest character, which is nonzero only in 9-bit mode. `rdData` shows bits 7:0 of the oldest character. Both are zero when the buffer is empty.
- R8: A character that arrives while both entries are full waits in the hold slot. It enters the buffer in the cycle that a read pops an entry, and it takes its place behind the remaining entry.
- R9: `overrun` rises after a `startDetect` that occurs while a character is held, the buffer is full and no read happens in that cycle. The held character is then discarded. `overrun` clears on the next read that pops an entry.
- R10: While `rxEnable` is low, the buffer, the hold slot and `overrun` are emptied, and `charValid` is ignored.
- R11: With both entries full and no character held, a read and a new character in the same cycle pop the oldest character and store the new one. The buffer stays full and nothing is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receiver enable; low flushes all state |
| charValid | input | 1 | One-cycle strobe: a character has completed in the shift register |
| charData | input | 9 | Received data bits, bit 8 is the ninth bit |
| charFrameErr | input | 1 | First stop bit of the character was zero |
| charParityErr | input | 1 | Parity mismatch computed for the character |
| parityCheckOn | input | 1 | Parity checking enabled at arrival |
| sizeSel | input | 3 | Character width code (see R6) |
| startDetect | input | 1 | One-cycle pulse: a new start bit has been detected |
| readStrobe | input | 1 | Data read; pops the oldest character |
| rxcIntEnable | input | 1 | Receive-complete interrupt enable |
| rdData | output | 8 | Low eight bits of the oldest character |
| rdBit8 | output | 1 | Ninth bit of the oldest character |
| rxComplete | output | 1 | At least one unread character stored |
| frameErr | output | 1 | Frame error of the oldest character |
| parityErr | output | 1 | Parity error of the oldest character |
| overrun | output | 1 | A held character was lost to a new start bit |
| rxIrq | output | 1 | Receive-complete interrupt request |

## Verification
The assertions assume that `charValid` does not pulse while a character is held unless a `startDetect` has discarded that character first. In the real port this holds because a new character can only complete after its own start bit. The random stimulus in the bench follows this rule: it offers a new character only when its reference model holds nothing. The directed sequences obey the same ordering. Start pulses, reads and enable drops are otherwise free. They may fall in the same cycle as arrivals and pops, so the bench exercises the orderings in which a read frees an entry and a start bit arrives on the same edge.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  localparam int CHAR_W = 9;
  localparam int SIZE_W = 3;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              frameErr;
    logic              parityErr;
  } rxEntry_t;

  typedef struct packed {
    logic flush;
    logic pop;
    logic push;
    logic pushFromHold;
    logic loadHold;
  } bufStrobe_t;

  function automatic logic [CHAR_W-1:0] trimChar(input logic [CHAR_W-1:0] raw,
                                                 input logic [SIZE_W-1:0] code);
    logic [CHAR_W-1:0] keep;
    case (code)
      3'd0:    keep = 9'h01F;
      3'd1:    keep = 9'h03F;
      3'd2:    keep = 9'h07F;
      3'd4:    keep = 9'h1FF;
      default: keep = 9'h0FF;
    endcase
    return raw & keep;
  endfunction

endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             charValid,
  input  logic             startDetect,
  input  logic             readStrobe,
  output bufStrobe_t       strobe,
  output logic [CNT_W-1:0] fillLevel,
  output logic             holdValid,
  output logic             overrunFlag
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             canPop;
  logic             holdMove;
  logic             newIn;
  logic             dropHold;
  logic [CNT_W-1:0] levelAfterPop;
  logic [CNT_W-1:0] levelMid;
  logic [CNT_W-1:0] levelNext;

  always_comb begin
    canPop        = rxEnable && readStrobe && (fillLevel != '0);
    levelAfterPop = fillLevel - CNT_W'(canPop);
    holdMove      = rxEnable && holdValid && (levelAfterPop < FULL);
    levelMid      = levelAfterPop + CNT_W'(holdMove);
    newIn         = rxEnable && charValid && !holdMove && (levelMid < FULL);
    dropHold      = rxEnable && startDetect && holdValid && !holdMove;
    levelNext     = levelMid + CNT_W'(newIn);

    strobe              = '0;
    strobe.flush        = !rxEnable;
    strobe.pop          = canPop;
    strobe.push         = holdMove || newIn;
    strobe.pushFromHold = holdMove;
    strobe.loadHold     = rxEnable && charValid && !newIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      fillLevel   <= '0;
      holdValid   <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      fillLevel <= levelNext;
      if (strobe.loadHold)
        holdValid <= 1'b1;
      else if (holdMove || dropHold)
        holdValid <= 1'b0;
      if (dropHold)
        overrunFlag <= 1'b1;
      else if (canPop)
        overrunFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [CHAR_W-1:0] charData,
  input  logic              charFrameErr,
  input  logic              charParityErr,
  input  logic              parityCheckOn,
  input  logic [SIZE_W-1:0] sizeSel,
  output rxEntry_t          headEntry
);

  rxEntry_t             slots [DEPTH];
  rxEntry_t             holdEntry;
  rxEntry_t             newEntry;
  rxEntry_t             pushEntry;
  logic     [PTR_W-1:0] wrPtr;
  logic     [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    newEntry.data      = trimChar(charData, sizeSel);
    newEntry.frameErr  = charFrameErr;
    newEntry.parityErr = charParityErr && parityCheckOn;
    pushEntry          = strobe.pushFromHold ? holdEntry : newEntry;
    headEntry          = slots[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      holdEntry <= '0;
    else if (strobe.loadHold)
      holdEntry <= newEntry;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)
        slots[s] <= '0;
      else if (strobe.push && (wrPtr == PTR_W'(s)))
        slots[s] <= pushEntry;
    end
  end

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       charValid,
  input  logic [8:0] charData,
  input  logic       charFrameErr,
  input  logic       charParityErr,
  input  logic       parityCheckOn,
  input  logic [2:0] sizeSel,
  input  logic       startDetect,
  input  logic       readStrobe,
  input  logic       rxcIntEnable,
  output logic [7:0] rdData,
  output logic       rdBit8,
  output logic       rxComplete,
  output logic       frameErr,
  output logic       parityErr,
  output logic       overrun,
  output logic       rxIrq
);

  bufStrobe_t       strobe;
  rxEntry_t         headEntry;
  logic [CNT_W-1:0] fillLevel;
  logic             holdValid;
  logic             overrunFlag;

  rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .charValid  (charValid),
    .startDetect(startDetect),
    .readStrobe (readStrobe),
    .strobe     (strobe),
    .fillLevel  (fillLevel),
    .holdValid  (holdValid),
    .overrunFlag(overrunFlag)
  );

  rxbuf_datapath #(.DEPTH(DEPTH)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .charData     (charData),
    .charFrameErr (charFrameErr),
    .charParityErr(charParityErr),
    .parityCheckOn(parityCheckOn),
    .sizeSel      (sizeSel),
    .headEntry    (headEntry)
  );

  always_comb begin
    rxComplete = (fillLevel != '0);
    rdData     = rxComplete ? headEntry.data[7:0] : '0;
    rdBit8     = rxComplete && headEntry.data[8];
    frameErr   = rxComplete && headEntry.frameErr;
    parityErr  = rxComplete && headEntry.parityErr;
    overrun    = overrunFlag;
    rxIrq      = rxComplete && rxcIntEnable;
  end

endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxEnable,
  input logic             charValid,
  input logic             startDetect,
  input logic             readStrobe,
  input logic             rxcIntEnable,
  input logic             rxComplete,
  input logic             frameErr,
  input logic             parityErr,
  input logic [7:0]       rdData,
  input logic             overrun,
  input logic             rxIrq,
  input logic             holdValid,
  input logic [CNT_W-1:0] fillLevel
);

  // R2
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxcIntEnable);

  // R4
  empty_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxComplete |-> (!frameErr && !parityErr && rdData == 8'h00));

  // R3
  pop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && readStrobe && rxComplete && !charValid && !holdValid)
      |=> (fillLevel == $past(fillLevel) - 1'b1));

  // R8
  hold_only_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> (fillLevel == CNT_W'(DEPTH)));

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(startDetect) && $past(holdValid) && !$past(readStrobe)));

  // R9
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && readStrobe && rxComplete) |=> !overrun);

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!rxComplete && !overrun && !holdValid));

endmodule

bind serial_rx_buffer rxbuf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rxEnable    (rxEnable),
  .charValid   (charValid),
  .startDetect (startDetect),
  .readStrobe  (readStrobe),
  .rxcIntEnable(rxcIntEnable),
  .rxComplete  (rxComplete),
  .frameErr    (frameErr),
  .parityErr   (parityErr),
  .rdData      (rdData),
  .overrun     (overrun),
  .rxIrq       (rxIrq),
  .holdValid   (holdValid),
  .fillLevel   (fillLevel)
);

// File: tb/test_serial_rx_buffer.sv
module test_serial_rx_buffer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0, cv = 1'b0, cfe = 1'b0, cpe = 1'b0, pon = 1'b0;
  logic [8:0] cd = '0;
  logic [2:0] sz = 3'd3;
  logic       st = 1'b0, rd = 1'b0, ie = 1'b0;
  logic [7:0] rdData;
  logic       rdBit8, rxComplete, frameErr, parityErr, overrun, rxIrq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  serial_rx_buffer i_serial_rx_buffer (
    .clk(clk), .rstN(rstN), .rxEnable(en), .charValid(cv), .charData(cd),
    .charFrameErr(cfe), .charParityErr(cpe), .parityCheckOn(pon), .sizeSel(sz),
    .startDetect(st), .readStrobe(rd), .rxcIntEnable(ie),
    .rdData(rdData), .rdBit8(rdBit8), .rxComplete(rxComplete), .frameErr(frameErr),
    .parityErr(parityErr), .overrun(overrun), .rxIrq(rxIrq)
  );

  typedef struct { logic [8:0] d; bit fe; bit pe; } ent_t;
  ent_t q[$];
  ent_t pendE;
  bit   pendV = 0;
  bit   ovr = 0;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (time %0t)", req, got, exp, $time);
    end
  endtask

  function automatic ent_t makeEnt();
    ent_t e;
    int w = (sz <= 3'd4) ? int'(sz) + 5 : 8;
    int m = (1 << w) - 1;
    e.d  = cd & m[8:0];
    e.fe = cfe;
    e.pe = cpe && pon;
    return e;
  endfunction

  task automatic modelStep();
    if (!rstN || !en) begin
      q.delete(); pendV = 0; ovr = 0;
    end else begin
      if (rd && q.size() > 0) begin
        void'(q.pop_front()); ovr = 0;
      end
      if (pendV && q.size() < 2) begin
        q.push_back(pendE); pendV = 0;
      end
      if (st && pendV) begin
        ovr = 1; pendV = 0;
      end
      if (cv) begin
        ent_t e = makeEnt();
        if (q.size() < 2) q.push_back(e);
        else begin pendE = e; pendV = 1; end
      end
    end
  endtask

  task automatic compareAll();
    bit   c   = q.size() > 0;
    logic [7:0] ed = c ? q[0].d[7:0] : 8'h00;
    bit   e8  = c ? q[0].d[8] : 1'b0;
    bit   efe = c ? q[0].fe : 1'b0;
    bit   epe = c ? q[0].pe : 1'b0;
    check(rxComplete == c, "R2 rxComplete", rxComplete, c);
    check(rxIrq == (c && ie), "R2 rxIrq", rxIrq, c && ie);
    check(rdData == ed, "R3/R6 rdData", rdData, ed);
    check(rdBit8 == e8, "R7 rdBit8", rdBit8, e8);
    check(frameErr == efe, "R4 frameErr", frameErr, efe);
    check(parityErr == epe, "R5 parityErr", parityErr, epe);
    check(overrun == ovr, "R9 overrun", overrun, ovr);
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    compareAll();
    cv = 0; st = 0; rd = 0;
  endtask

  task automatic sendChar(input logic [8:0] d, input bit fe, input bit pe);
    cd = d; cfe = fe; cpe = pe; cv = 1;
    tick();
  endtask

  task automatic readOne();
    rd = 1;
    tick();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    check(!rxComplete && !overrun && rdData == 0 && !rxIrq, "R1 reset", rxComplete, 0);
    rstN = 1;
    tick();
    check(!rxComplete && !frameErr && !parityErr && !rdBit8, "R1 after reset", rxComplete, 0);
    en = 1; ie = 1; pon = 1; sz = 3'd3;
    tick();

    // R3: order and empty read
    sendChar(9'h05A, 0, 0);
    sendChar(9'h0C3, 1, 0);
    check(rdData == 8'h5A && !frameErr, "R3 head first", rdData, 8'h5A);
    readOne();
    // R4: status of new head
    check(rdData == 8'hC3 && frameErr, "R4 second head fe", frameErr, 1);
    readOne();
    check(!rxComplete && !rxIrq, "R2 empty after reads", rxComplete, 0);
    readOne();
    check(!rxComplete && rdData == 0, "R3 empty read ignored", rdData, 0);

    // R5: parity gating
    pon = 0; sendChar(9'h011, 0, 1);
    pon = 1; sendChar(9'h022, 0, 1);
    check(!parityErr, "R5 parity ignored when off", parityErr, 0);
    readOne();
    check(parityErr && rdData == 8'h22, "R5 parity recorded", parityErr, 1);
    readOne();

    // R6/R7: width masking
    for (int k = 0; k < 8; k++) begin
      sz = k[2:0];
      sendChar(9'h1FF, 0, 0);
      case (k)
        0: check(rdData == 8'h1F && !rdBit8, "R6 5-bit", rdData, 8'h1F);
        1: check(rdData == 8'h3F && !rdBit8, "R6 6-bit", rdData, 8'h3F);
        2: check(rdData == 8'h7F && !rdBit8, "R6 7-bit", rdData, 8'h7F);
        4: check(rdData == 8'hFF && rdBit8, "R7 9-bit ninth bit", rdBit8, 1);
        default: check(rdData == 8'hFF && !rdBit8, "R6 8-bit", rdData, 8'hFF);
      endcase
      readOne();
    end
    sz = 3'd3;

    // R8: hold slot moves in on read
    sendChar(9'h0A1, 0, 0);
    sendChar(9'h0A2, 0, 0);
    sendChar(9'h0A3, 1, 0);
    check(rdData == 8'hA1, "R8 held char not visible", rdData, 8'hA1);
    readOne();
    check(rdData == 8'hA2, "R8 order after move", rdData, 8'hA2);
    readOne();
    check(rdData == 8'hA3 && frameErr, "R8 held char stored", rdData, 8'hA3);
    readOne();
    check(!rxComplete, "R8 drained", rxComplete, 0);

    // R9: overrun drops held char
    sendChar(9'h0B1, 0, 0);
    sendChar(9'h0B2, 0, 0);
    sendChar(9'h0B3, 0, 0);
    st = 1; tick();
    check(overrun, "R9 overrun set", overrun, 1);
    readOne();
    check(!overrun && rdData == 8'hB2, "R9 cleared by read", overrun, 0);
    readOne();
    check(!rxComplete, "R9 held char lost", rxComplete, 0);

    // R9: start in same cycle as read: no overrun
    sendChar(9'h0C1, 0, 0);
    sendChar(9'h0C2, 0, 0);
    sendChar(9'h0C3, 0, 0);
    st = 1; rd = 1; tick();
    check(!overrun && rdData == 8'hC2, "R9 read beats start", overrun, 0);
    readOne();
    check(rdData == 8'hC3, "R9 held char kept", rdData, 8'hC3);
    readOne();

    // R11: read and arrival together while full
    sendChar(9'h0D1, 0, 0);
    sendChar(9'h0D2, 0, 0);
    cd = 9'h0D3; cfe = 0; cpe = 0; cv = 1; rd = 1; tick();
    check(rdData == 8'hD2, "R11 pop and push", rdData, 8'hD2);
    readOne();
    check(rdData == 8'hD3, "R11 new char stored", rdData, 8'hD3);
    readOne();
    readOne();

    // R10: flush and ignore while disabled
    sendChar(9'h0E1, 1, 1);
    sendChar(9'h0E2, 0, 0);
    sendChar(9'h0E3, 0, 0);
    st = 1; tick();
    en = 0; tick();
    check(!rxComplete && !overrun && !frameErr, "R10 flush", rxComplete, 0);
    sendChar(9'h0E4, 0, 0);
    check(!rxComplete, "R10 arrival ignored", rxComplete, 0);
    en = 1; tick();
    check(!rxComplete && !overrun, "R10 stays empty", rxComplete, 0);

    // R2: interrupt enable gating
    ie = 0; sendChar(9'h0F0, 0, 0);
    check(rxComplete && !rxIrq, "R2 irq masked", rxIrq, 0);
    ie = 1; tick();
    check(rxIrq, "R2 irq raised", rxIrq, 1);
    readOne();

    // random phase, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      en  = (r < 97);
      cv  = !pendV && ($urandom_range(0, 2) == 0);
      cd  = 9'($urandom);
      cfe = $urandom_range(0, 3) == 0;
      cpe = $urandom_range(0, 3) == 0;
      pon = $urandom_range(0, 1);
      sz  = 3'($urandom_range(0, 7));
      st  = $urandom_range(0, 3) == 0;
      rd  = $urandom_range(0, 3) == 0;
      ie  = $urandom_range(0, 1);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule